// File: doc/BRIEF.md
# DSI Command Packet Transmitter

This block assembles a single MIPI DSI command packet from values software has placed in a small register file. It then streams the packet one byte at a time to a lane-level serializer. Software programs a header word and, for long packets, up to four 32-bit payload words, and then writes a start request. The engine emits the four header bytes, including a Hamming ECC computed in hardware. A long packet then carries its payload bytes and a 16-bit CRC. At the end the engine either flags plain completion or pulses a bus-turnaround request, so a peripheral can answer.

The byte output uses a valid/ready handshake, and the serializer may stall it at any byte. Completion and two externally reported fault conditions are collected in a write-one-to-clear status word. Each status bit has a matching enable bit, and the interrupt output is the OR of the enabled, set bits. A configuration bit selects low-power or high-speed transmission, and it is presented to the lane logic for the duration of the packet.

Register word addresses: 0 configuration, 1 control, 2 status, 3 interrupt enable, 4 header, 5 to 8 payload words 0 to 3.

Top module: `dsi_cmd_tx`

## Requirements
- R1: After reset, tx_valid, bta_req and irq are low and the status word (address 2) reads zero.
- R2: The header word (address 4) holds the format select in bit 24 (1 = long), the virtual channel in bits 23:22, the data type in bits 21:16, the second parameter or word-count high byte in bits 15:8, and the first parameter or word-count low byte in bits 7:0. The first bytes sent are bits 23:16, then bits 7:0, then bits 15:8.
- R3: The fourth byte is the ECC of header bits 23:0. Its bits 5:0 are the six parity bits of the standard DSI Hamming code, and its bits 7:6 are zero.
- R4: A short packet (bit 24 = 0) is exactly four bytes long, with tx_last asserted on the fourth, and sends no payload.
- R5: A long packet sends word-count ({bits 15:8, bits 7:0}) payload bytes after the ECC, in ascending order. Byte 4w+b is taken from bits 8b+7:8b of the payload word at address 5+w.
- R6: A long packet ends with a CRC over the payload bytes: reflected polynomial 0x8408 (x^16+x^12+x^5+1), initial value 0xFFFF, no final inversion. The low byte goes first and tx_last is set on the high byte. A word count of 0 sends FF, FF.
- R7: A word count above 16 sends exactly 16 payload bytes. The header bytes are sent as written.
- R8: While tx_valid is high and tx_ready is low, tx_data and tx_valid hold. The engine advances only on a cycle with both high.
- R9: Writing control (address 1) with bit 0 set and bit 1 clear starts a plain send. Status bit 0 is set on the second clock edge after the last byte is accepted, and bta_req stays low.
- R10: Writing control with bit 1 set, with bit 0 ignored in that case, starts a send with turnaround. In the cycle after the last byte is accepted, bta_req is high for one cycle and bta_type equals the control bit 2 written at start. Status bit 1 is set one edge later.
- R11: While a packet is in flight, start requests and writes to configuration, header and payload registers have no effect.
- R12: Status bits are cleared by writing 1 to them. Bit 16 is set by err_bus and bit 18 by err_collision. A set in the same cycle wins over a clear.
- R13: irq is high exactly when some status bit is set and its enable bit, at the same position in address 3, is set.
- R14: tx_lp follows configuration bit 8 (1 = low power).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| err_bus | input | 1 | Bus fault report, sets status bit 16 |
| err_collision | input | 1 | Contention fault report, sets status bit 18 |
| tx_data | output | 8 | Packet byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_lp | output | 1 | Low-power transmission select |
| bta_req | output | 1 | One-cycle bus-turnaround request |
| bta_type | output | 1 | Turnaround type for bta_req |
| irq | output | 1 | Interrupt |

## Verification
A start written on one clock edge puts the first header byte on tx_data in the following cycle. Each byte is accepted on the edge where tx_valid and tx_ready are both high. bta_req is due in the cycle right after the last byte's accepting edge, and the completion status bit one edge after that. The bench's monitor compares every accepted byte with a scoreboard queue at the falling edge. The driver stops at the rising edge where the queue empties, then samples bta_req just after that edge and reads the status one edge later. Register and fault effects are read back one edge after the write or pulse.

// File: rtl/dsi_tx_pkg.sv
package dsi_tx_pkg;

  localparam int unsigned REG_CFG  = 0;
  localparam int unsigned REG_CTL  = 1;
  localparam int unsigned REG_STS  = 2;
  localparam int unsigned REG_IEN  = 3;
  localparam int unsigned REG_HDR  = 4;
  localparam int unsigned REG_PAY0 = 5;

  localparam int unsigned CFG_LP_BIT = 8;
  localparam int unsigned CTL_SEND   = 0;
  localparam int unsigned CTL_BTA    = 1;
  localparam int unsigned CTL_BTYPE  = 2;
  localparam int unsigned HDR_LONG   = 24;

  localparam int unsigned STS_TX  = 0;
  localparam int unsigned STS_BTA = 1;
  localparam int unsigned STS_BUS = 16;
  localparam int unsigned STS_COL = 18;
  localparam logic [31:0] STS_MASK = (32'h1 << STS_TX) | (32'h1 << STS_BTA)
                                   | (32'h1 << STS_BUS) | (32'h1 << STS_COL);

  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_CRC} seq_state_t;

  // Coverage masks of the six header parity bits over the 24 header bits
  function automatic logic [23:0] ecc_mask(input int idx);
    case (idx)
      0:       return 24'hF12CB7;
      1:       return 24'hF2555B;
      2:       return 24'h749A6D;
      3:       return 24'hB8E38E;
      4:       return 24'hDF03F0;
      5:       return 24'hEFFC00;
      default: return 24'h000000;
    endcase
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] cur, input logic [7:0] din);
    logic [15:0] r;
    r = cur ^ {8'h00, din};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/dsi_tx_ecc.sv
module dsi_tx_ecc
  import dsi_tx_pkg::*;
#(
  parameter int unsigned PAR_BITS = 6
) (
  input  logic [23:0] hdr_bits,
  output logic [7:0]  ecc
);

  for (genvar g = 0; g < PAR_BITS; g++) begin : g_par
    assign ecc[g] = ^(hdr_bits & ecc_mask(g));
  end
  assign ecc[7:PAR_BITS] = '0;

endmodule

// File: rtl/dsi_tx_crc.sv
module dsi_tx_crc
  import dsi_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr) begin
      crc_d = CRC_INIT;
    end else if (en) begin
      crc_d = crc_step(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_INIT;
    end else if (clr || en) begin
      crc_q <= crc_d;
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/dsi_tx_regs.sv
module dsi_tx_regs
  import dsi_tx_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned PAY_WORDS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic                    busy,
  input  logic                    fin_tx,
  input  logic                    fin_bta,
  input  logic                    err_bus,
  input  logic                    err_col,
  output logic                    start,
  output logic                    start_bta,
  output logic                    start_type,
  output logic                    cfg_lp,
  output logic [24:0]             hdr,
  output logic [PAY_WORDS*32-1:0] pay_flat,
  output logic                    irq
);

  logic        lp_q;
  logic [24:0] hdr_q;
  logic [31:0] sts_q, sts_d, ien_q;
  logic [31:0] pay_q [PAY_WORDS];
  logic        wr_cfg, wr_hdr, wr_sts, wr_ien, wr_ctl;
  logic [31:0] sts_set;

  assign wr_cfg = wr && (addr == AW'(REG_CFG)) && !busy;
  assign wr_hdr = wr && (addr == AW'(REG_HDR)) && !busy;
  assign wr_ctl = wr && (addr == AW'(REG_CTL));
  assign wr_sts = wr && (addr == AW'(REG_STS));
  assign wr_ien = wr && (addr == AW'(REG_IEN));

  assign start      = wr_ctl && !busy && (wdata[CTL_SEND] || wdata[CTL_BTA]);
  assign start_bta  = wdata[CTL_BTA];
  assign start_type = wdata[CTL_BTYPE];

  always_comb begin
    sts_set = '0;
    sts_set[STS_TX]  = fin_tx;
    sts_set[STS_BTA] = fin_bta;
    sts_set[STS_BUS] = err_bus;
    sts_set[STS_COL] = err_col;
    sts_d = sts_q;
    if (wr_sts) begin
      sts_d = sts_d & ~wdata;
    end
    sts_d = (sts_d | sts_set) & STS_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q  <= 1'b0;
      hdr_q <= '0;
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      sts_q <= sts_d;
      if (wr_cfg) lp_q  <= wdata[CFG_LP_BIT];
      if (wr_hdr) hdr_q <= wdata[24:0];
      if (wr_ien) ien_q <= wdata & STS_MASK;
    end
  end

  for (genvar w = 0; w < PAY_WORDS; w++) begin : g_pay
    logic wr_pay;
    assign wr_pay = wr && (addr == AW'(REG_PAY0 + w)) && !busy;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pay_q[w] <= '0;
      end else if (wr_pay) begin
        pay_q[w] <= wdata;
      end
    end
    assign pay_flat[w*32 +: 32] = pay_q[w];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(REG_CFG): rdata[CFG_LP_BIT] = lp_q;
      AW'(REG_STS): rdata = sts_q;
      AW'(REG_IEN): rdata = ien_q;
      AW'(REG_HDR): rdata = {7'd0, hdr_q};
      default: begin
        for (int w = 0; w < PAY_WORDS; w++) begin
          if (addr == AW'(REG_PAY0 + w)) rdata = pay_q[w];
        end
      end
    endcase
  end

  assign cfg_lp = lp_q;
  assign hdr    = hdr_q;
  assign irq    = |(sts_q & ien_q);

  AST_HDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && addr == AW'(REG_HDR)) |=> $stable(hdr_q)); // R11
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[STS_TX] && wr_sts && wdata[STS_TX] && !fin_tx) |=> !sts_q[STS_TX]); // R12
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    err_bus |=> sts_q[STS_BUS]); // R12

endmodule

// File: rtl/dsi_tx_seq.sv
module dsi_tx_seq
  import dsi_tx_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   start_bta,
  input  logic                   start_type,
  input  logic [24:0]            hdr,
  input  logic [MAX_BYTES*8-1:0] pay_flat,
  input  logic [7:0]             ecc,
  input  logic [15:0]            crc,
  output logic [7:0]             tx_data,
  output logic                   tx_valid,
  output logic                   tx_last,
  input  logic                   tx_ready,
  output logic                   busy,
  output logic                   crc_clr,
  output logic                   crc_en,
  output logic                   fin_tx,
  output logic                   fin_bta,
  output logic                   bta_req,
  output logic                   bta_type
);

  localparam int unsigned CW = $clog2(MAX_BYTES + 1);
  localparam int unsigned IW = $clog2(MAX_BYTES);

  seq_state_t     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  n_pay;
  logic           fin_q, fin_d, mode_q, type_q;
  logic           is_long, fire;

  assign is_long = hdr[HDR_LONG];
  assign n_pay   = (hdr[15:0] > 16'(MAX_BYTES)) ? CW'(MAX_BYTES) : CW'(hdr[15:0]);
  assign fire    = tx_valid && tx_ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fin_d   = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_HDR;
        cnt_d   = '0;
      end
      ST_HDR: if (fire) begin
        if (cnt_q == CW'(3)) begin
          cnt_d = '0;
          if (!is_long) begin
            state_d = ST_IDLE;
            fin_d   = 1'b1;
          end else if (n_pay == '0) begin
            state_d = ST_CRC;
          end else begin
            state_d = ST_PAY;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAY: if (fire) begin
        if (cnt_q == CW'(n_pay - 1'b1)) begin
          cnt_d   = '0;
          state_d = ST_CRC;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CRC: if (fire) begin
        if (cnt_q[0]) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
          fin_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
      mode_q  <= 1'b0;
      type_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fin_q   <= fin_d;
      if (start && state_q == ST_IDLE) begin
        mode_q <= start_bta;
        type_q <= start_type;
      end
    end
  end

  always_comb begin
    tx_data = '0;
    tx_last = 1'b0;
    case (state_q)
      ST_HDR: begin
        case (cnt_q[1:0])
          2'd0:    tx_data = hdr[23:16];
          2'd1:    tx_data = hdr[7:0];
          2'd2:    tx_data = hdr[15:8];
          default: tx_data = ecc;
        endcase
        tx_last = (cnt_q == CW'(3)) && !is_long;
      end
      ST_PAY:  tx_data = pay_flat[{cnt_q[IW-1:0], 3'b000} +: 8];
      ST_CRC: begin
        tx_data = cnt_q[0] ? crc[15:8] : crc[7:0];
        tx_last = cnt_q[0];
      end
      default: ;
    endcase
  end

  assign tx_valid = (state_q != ST_IDLE);
  assign busy     = (state_q != ST_IDLE);
  assign crc_clr  = start && (state_q == ST_IDLE);
  assign crc_en   = fire && (state_q == ST_PAY);
  assign fin_tx   = fin_q && !mode_q;
  assign fin_bta  = fin_q && mode_q;
  assign bta_req  = fin_bta;
  assign bta_type = type_q;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R8
  AST_PAY_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAY) |-> (cnt_q < CW'(MAX_BYTES))); // R7
  AST_SHORT_NO_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAY) |-> is_long); // R4
  AST_BTA_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    bta_req |-> $past(tx_valid && tx_ready && tx_last)); // R10

endmodule

// File: rtl/dsi_cmd_tx.sv
module dsi_cmd_tx
  import dsi_tx_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned PAY_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          err_bus,
  input  logic          err_collision,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          tx_lp,
  output logic          bta_req,
  output logic          bta_type,
  output logic          irq
);

  localparam int unsigned MAX_BYTES = PAY_WORDS * 4;

  logic                   busy, fin_tx, fin_bta;
  logic                   start, start_bta, start_type;
  logic [24:0]            hdr;
  logic [PAY_WORDS*32-1:0] pay_flat;
  logic [7:0]             ecc;
  logic [15:0]            crc;
  logic                   crc_clr, crc_en;

  dsi_tx_regs #(.AW(AW), .PAY_WORDS(PAY_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .fin_tx(fin_tx), .fin_bta(fin_bta),
    .err_bus(err_bus), .err_col(err_collision), .start(start),
    .start_bta(start_bta), .start_type(start_type), .cfg_lp(tx_lp),
    .hdr(hdr), .pay_flat(pay_flat), .irq(irq)
  );

  dsi_tx_ecc u_ecc (
    .hdr_bits(hdr[23:0]), .ecc(ecc)
  );

  dsi_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(tx_data), .crc(crc)
  );

  dsi_tx_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_bta(start_bta),
    .start_type(start_type), .hdr(hdr), .pay_flat(pay_flat), .ecc(ecc),
    .crc(crc), .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .busy(busy), .crc_clr(crc_clr), .crc_en(crc_en),
    .fin_tx(fin_tx), .fin_bta(fin_bta), .bta_req(bta_req), .bta_type(bta_type)
  );

endmodule

// File: tb/dsi_cmd_tx_tb.sv
module dsi_cmd_tx_tb;

  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          err_bus = 1'b0, err_collision = 1'b0;
  logic [7:0]    tx_data;
  logic          tx_valid, tx_last;
  logic          tx_ready = 1'b1;
  logic          tx_lp, bta_req, bta_type, irq;

  always #4 clk = ~clk;

  dsi_cmd_tx u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_bus(err_bus),
    .err_collision(err_collision), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready), .tx_lp(tx_lp), .bta_req(bta_req),
    .bta_type(bta_type), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [8:0]  sb_q [$];
  logic [31:0] pay_m [4];
  logic        rdy_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_ecc(input logic [23:0] d);
    logic [7:0] p;
    p = '0;
    p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
    p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
    p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
    p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
    p[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
    p[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
    return p;
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ b[i];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  // ready pattern driver
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = rdy_rand ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  // monitor: compares accepted bytes against the scoreboard
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check("R8 byte held under stall", {31'd0, tx_valid} << 8 | tx_data, {23'd0, 1'b1, prev_data});
      if (tx_valid && tx_ready) begin
        if (sb_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R11 unexpected byte actual=%h expected=none", tx_data);
        end else begin
          logic [8:0] e;
          e = sb_q.pop_front();
          check("R2/R3/R4/R5/R6/R7 stream byte {last,data}", {23'd0, tx_last, tx_data}, {23'd0, e});
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic push_expected(input logic [31:0] hdr);
    int n;
    logic [15:0] c;
    logic [15:0] wc;
    sb_q.push_back({1'b0, hdr[23:16]});
    sb_q.push_back({1'b0, hdr[7:0]});
    sb_q.push_back({1'b0, hdr[15:8]});
    sb_q.push_back({!hdr[24], ref_ecc(hdr[23:0])});
    if (hdr[24]) begin
      wc = hdr[15:0];
      n  = (wc > 16) ? 16 : int'(wc);
      c  = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        b = pay_m[i/4][(i%4)*8 +: 8];
        sb_q.push_back({1'b0, b});
        c = ref_crc(c, b);
      end
      sb_q.push_back({1'b0, c[7:0]});
      sb_q.push_back({1'b1, c[15:8]});
    end
  endtask

  task automatic wait_done(input logic [2:0] ctl);
    logic [31:0] s;
    logic bta;
    bta = ctl[1];
    while (sb_q.size() != 0) @(posedge clk);
    #1;
    check("R9/R10 bta_req after last byte", {31'd0, bta_req}, {31'd0, bta});
    if (bta) check("R10 bta_type", {31'd0, bta_type}, {31'd0, ctl[2]});
    @(posedge clk); #1;
    check("R9/R10 tx_valid idle", {31'd0, tx_valid}, 32'd0);
    rd(2, s);
    check("R9/R10 completion status", s, bta ? 32'h2 : 32'h1);
    wr(2, 32'h3);
    rd(2, s);
    check("R12 status cleared by write-one", s, 32'h0);
  endtask

  task automatic send(input logic [31:0] hdr, input logic [2:0] ctl);
    wr(4, hdr);
    for (int w = 0; w < 4; w++) wr(5 + w, pay_m[w]);
    push_expected(hdr);
    wr(1, {29'd0, ctl});
    wait_done(ctl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] s;
    pay_m[0] = 32'h44332211; pay_m[1] = 32'h88776655;
    pay_m[2] = 32'hCCBBAA99; pay_m[3] = 32'h00FFEEDD;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R1 bta_req", {31'd0, bta_req}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(2, s);
    check("R1 status", s, 32'd0);

    // R14 low-power select
    wr(0, 32'h100);
    check("R14 tx_lp set", {31'd0, tx_lp}, 32'd1);
    wr(0, 32'h0);
    check("R14 tx_lp clear", {31'd0, tx_lp}, 32'd0);

    // R2 R3 R4 short packets, ready always and random
    send(32'h0055A53C, 3'b001);
    rdy_rand = 1'b1;
    send(32'h00C30001, 3'b001);
    send(32'h00FFFFFF, 3'b001);

    // R5 R6 long packets
    send(32'h01290005, 3'b001);
    send(32'h01390000, 3'b001);
    send(32'h01290010, 3'b001);
    // R7 clamp
    send(32'h01290014, 3'b001);

    // R10 turnaround with type 1, then both start bits with type 0
    send(32'h00370001, 3'b110);
    send(32'h00060000, 3'b011);

    // R11 start and writes ignored while busy
    wr(4, 32'h01290010);
    push_expected(32'h01290010);
    wr(1, 32'h1);
    wr(4, 32'h00111111);
    wr(5, 32'hDEADBEEF);
    wr(0, 32'h100);
    check("R11 tx_lp unchanged while busy", {31'd0, tx_lp}, 32'd0);
    wr(1, 32'h2);
    wait_done(3'b001);
    repeat (40) @(posedge clk);
    #1;
    check("R11 no second packet", {31'd0, tx_valid}, 32'd0);
    rd(4, s);
    check("R11 header unchanged", s, 32'h01290010);
    rd(5, s);
    check("R11 payload unchanged", s, pay_m[0]);
    rdy_rand = 1'b0;

    // R12 R13 faults and interrupt
    @(posedge clk); #1 err_bus = 1'b1;
    @(posedge clk); #1 err_bus = 1'b0;
    rd(2, s);
    check("R12 bus fault status", s, 32'h00010000);
    check("R13 irq masked", {31'd0, irq}, 32'd0);
    wr(3, 32'h00010000);
    check("R13 irq enabled", {31'd0, irq}, 32'd1);
    @(posedge clk); #1 err_collision = 1'b1;
    @(posedge clk); #1 err_collision = 1'b0;
    rd(2, s);
    check("R12 collision status", s, 32'h00050000);
    wr(2, 32'h00010000);
    rd(2, s);
    check("R12 partial clear", s, 32'h00040000);
    check("R13 irq drops", {31'd0, irq}, 32'd0);
    wr(2, 32'h00040000);
    // R12 set wins over clear in the same cycle
    @(posedge clk); #1;
    err_bus = 1'b1; reg_wr = 1'b1; reg_addr = AW'(2); reg_wdata = 32'h00010000;
    @(posedge clk); #1;
    err_bus = 1'b0; reg_wr = 1'b0;
    rd(2, s);
    check("R12 set beats clear", s, 32'h00010000);
    wr(2, 32'h00010000);
    // R13 irq on completion
    wr(3, 32'h1);
    wr(4, 32'h00050203);
    push_expected(32'h00050203);
    wr(1, 32'h1);
    while (sb_q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
    check("R13 irq on done", {31'd0, irq}, 32'd1);
    wr(2, 32'h1);
    check("R13 irq after clear", {31'd0, irq}, 32'd0);

    repeat (5) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule